// File: doc/BRIEF.md
# Input Clock Frequency Range Monitor

This block watches a group of asynchronous input clocks and decides, for each one, whether its frequency lies within a tolerance window around the nominal rate. It uses a fast free-running master clock as the time base. Each input is brought into the master domain and its rising edges are detected. The block then counts how many master cycles a fixed number of input periods take. If the count falls outside a window of plus or minus a set number of parts per million around the expected count, the input is declared invalid. An input that stops toggling is caught by a timeout. The default window is 10,000 ppm, which is one percent.

For each input the block keeps a live valid bit and a sticky change flag, and it drives a combined interrupt request. The change flag is set whenever the valid bit flips, in either direction. The interrupt request is gated by a per-input enable mask. A selectability mask for a downstream reference selector is also driven, and it carries a 0 for any input that is currently invalid. A global check-enable input turns the range check off. While it is off, every input counts as valid. Software access is reduced to plain inputs: the check enable, a write-one-to-clear mask for the sticky flags, and the interrupt enable mask.

Top module: `clkfreq_guard`

## Requirements
- R1: With expected count E = NOM_CYC*WIN_EDGES master cycles and deviation D = floor(E*TOL_PPM/1000000), an input whose WIN_EDGES consecutive periods span a count in [E-D, E+D] is reported valid (bit i of every mask belongs to input i; defaults E=320, D=3).
- R2: An input whose measured span lies outside [E-D, E+D] is reported invalid. This includes an input that is too slow, one that is too fast, and one that has stopped, which is caught once E+D+1 master cycles pass without a finished window.
- R3: While chk_en_i is 0, every bit of valid_o is 1 from the next master clock edge onward, whatever the input clocks do.
- R4: valid_o is a registered real-time status that follows the most recent verdict of each input's measurement.
- R5: A chg_o bit is set on the clock edge at which the matching valid_o bit changes, whether it rises or falls.
- R6: A chg_o bit stays set until a 1 is written to the same bit of clr_i. If a valid transition happens on the same edge as that clear, the bit stays set.
- R7: irq_o is 1 one cycle after any bit of chg_o is 1 while the same bit of irq_en_i is 1. Otherwise it is 0.
- R8: sel_ok_o carries the same value as valid_o, so an invalid input is never offered for automatic selection.
- R9: Synchronous reset clears valid_o, sel_ok_o, chg_o and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master time-base clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | NUM_IN | Asynchronous input clocks under test |
| chk_en_i | input | 1 | Frequency range check enable |
| clr_i | input | NUM_IN | Write-one-to-clear for sticky change flags |
| irq_en_i | input | NUM_IN | Interrupt enable mask |
| valid_o | output | NUM_IN | Real-time valid status per input |
| chg_o | output | NUM_IN | Sticky valid-transition flags |
| irq_o | output | 1 | Interrupt request |
| sel_ok_o | output | NUM_IN | Selectability mask for reference selection |

## Verification
The properties assume that chk_en_i, clr_i and irq_en_i are synchronous to mclk and hold steady around each rising edge. Only ref_clk_i is taken to be asynchronous. The stimulus changes every control input on the falling edge of mclk. The test clocks are also built on falling edges from whole numbers of master cycles, so every measured span is an exact multiple of the chosen input period. Test periods are picked well inside or well outside the tolerance window, so each verdict is clear-cut and does not depend on synchronizer phase.

// File: rtl/clkfreq_pkg.sv
package clkfreq_pkg;

  // Measurement result handed from a meter to the status bank.
  typedef struct packed {
    logic done;
    logic pass;
  } meas_res_t;

  // Deviation in master cycles allowed around the expected count.
  function automatic longint unsigned tol_cycles(input longint unsigned expected,
                                                 input longint unsigned ppm);
    return (expected * ppm) / 64'd1000000;
  endfunction

endpackage

// File: rtl/clkfreq_edge_sync.sv
module clkfreq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic mclk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge mclk) begin
    if (rst) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= {pipe_q[DEPTH-2:0], async_i};
    end
  end

  // Rising edge seen on the last synchronized stage.
  assign rise_o = pipe_q[DEPTH-2] & ~pipe_q[DEPTH-1];

endmodule

// File: rtl/clkfreq_window_meter.sv
module clkfreq_window_meter
  import clkfreq_pkg::*;
#(
  parameter int NOM_CYC   = 20,
  parameter int WIN_EDGES = 16,
  parameter int TOL_PPM   = 10000
) (
  input  logic      mclk,
  input  logic      rst,
  input  logic      rise_i,
  output meas_res_t res_o
);

  localparam longint unsigned EXP_CNT = longint'(NOM_CYC) * longint'(WIN_EDGES);
  localparam longint unsigned DEV_CNT = tol_cycles(EXP_CNT, longint'(TOL_PPM));
  localparam longint unsigned LO_CNT  = EXP_CNT - DEV_CNT;
  localparam longint unsigned HI_CNT  = EXP_CNT + DEV_CNT;
  localparam int CNT_W = $clog2(HI_CNT + 2);
  localparam int EDG_W = $clog2(WIN_EDGES + 1);
  localparam logic [CNT_W-1:0] LO_V   = CNT_W'(LO_CNT);
  localparam logic [CNT_W-1:0] HI_V   = CNT_W'(HI_CNT);
  localparam logic [EDG_W-1:0] LAST_E = EDG_W'(WIN_EDGES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [EDG_W-1:0] edg_q;
  logic             armed_q;
  meas_res_t        res_q;

  logic [CNT_W-1:0] elapsed;
  logic             over;
  logic             last_edge;

  assign elapsed   = cnt_q + CNT_W'(1);
  assign over      = (elapsed > HI_V);
  assign last_edge = rise_i && armed_q && (edg_q == LAST_E);

  always_ff @(posedge mclk) begin
    if (rst) begin
      cnt_q   <= '0;
      edg_q   <= '0;
      armed_q <= 1'b0;
      res_q   <= '0;
    end else begin
      res_q.done <= 1'b0;
      if (over) begin
        // Window ran past the upper limit: too slow or stopped.
        res_q.done <= 1'b1;
        res_q.pass <= 1'b0;
        armed_q    <= 1'b0;
        cnt_q      <= '0;
        edg_q      <= '0;
      end else if (rise_i && !armed_q) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
        edg_q   <= '0;
      end else if (last_edge) begin
        // Closing edge doubles as the next window's opening edge.
        res_q.done <= 1'b1;
        res_q.pass <= (elapsed >= LO_V);
        cnt_q      <= '0;
        edg_q      <= '0;
      end else begin
        cnt_q <= elapsed;
        if (rise_i) begin
          edg_q <= edg_q + EDG_W'(1);
        end
      end
    end
  end

  assign res_o = res_q;

endmodule

// File: rtl/clkfreq_status_bank.sv
module clkfreq_status_bank
  import clkfreq_pkg::*;
#(
  parameter int NUM_IN = 4
) (
  input  logic              mclk,
  input  logic              rst,
  input  meas_res_t         res_i [NUM_IN],
  input  logic              chk_en_i,
  input  logic [NUM_IN-1:0] clr_i,
  input  logic [NUM_IN-1:0] irq_en_i,
  output logic [NUM_IN-1:0] valid_o,
  output logic [NUM_IN-1:0] chg_o,
  output logic              irq_o,
  output logic [NUM_IN-1:0] sel_ok_o
);

  logic [NUM_IN-1:0] valid_q, chg_q, sel_q;
  logic [NUM_IN-1:0] valid_nxt, flip, chg_nxt;
  logic              irq_q;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    always_comb begin
      if (!chk_en_i) begin
        valid_nxt[g] = 1'b1;
      end else if (res_i[g].done) begin
        valid_nxt[g] = res_i[g].pass;
      end else begin
        valid_nxt[g] = valid_q[g];
      end
    end
  end

  assign flip    = valid_nxt ^ valid_q;
  assign chg_nxt = (chg_q & ~clr_i) | flip;

  always_ff @(posedge mclk) begin
    if (rst) begin
      valid_q <= '0;
      sel_q   <= '0;
      chg_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      valid_q <= valid_nxt;
      sel_q   <= valid_nxt;
      chg_q   <= chg_nxt;
      irq_q   <= |(chg_q & irq_en_i);
    end
  end

  assign valid_o  = valid_q;
  assign chg_o    = chg_q;
  assign irq_o    = irq_q;
  assign sel_ok_o = sel_q;

endmodule

// File: rtl/clkfreq_guard.sv
module clkfreq_guard
  import clkfreq_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int SYNC_FF   = 2,
  parameter int NOM_CYC   = 20,
  parameter int WIN_EDGES = 16,
  parameter int TOL_PPM   = 10000
) (
  input  logic              mclk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] ref_clk_i,
  input  logic              chk_en_i,
  input  logic [NUM_IN-1:0] clr_i,
  input  logic [NUM_IN-1:0] irq_en_i,
  output logic [NUM_IN-1:0] valid_o,
  output logic [NUM_IN-1:0] chg_o,
  output logic              irq_o,
  output logic [NUM_IN-1:0] sel_ok_o
);

  logic [NUM_IN-1:0] rise;
  meas_res_t         res [NUM_IN];

  for (genvar g = 0; g < NUM_IN; g++) begin : g_in
    clkfreq_edge_sync #(
      .STAGES (SYNC_FF)
    ) sync_i (
      .mclk    (mclk),
      .rst     (rst),
      .async_i (ref_clk_i[g]),
      .rise_o  (rise[g])
    );

    clkfreq_window_meter #(
      .NOM_CYC   (NOM_CYC),
      .WIN_EDGES (WIN_EDGES),
      .TOL_PPM   (TOL_PPM)
    ) meter_i (
      .mclk   (mclk),
      .rst    (rst),
      .rise_i (rise[g]),
      .res_o  (res[g])
    );
  end

  clkfreq_status_bank #(
    .NUM_IN (NUM_IN)
  ) status_i (
    .mclk     (mclk),
    .rst      (rst),
    .res_i    (res),
    .chk_en_i (chk_en_i),
    .clr_i    (clr_i),
    .irq_en_i (irq_en_i),
    .valid_o  (valid_o),
    .chg_o    (chg_o),
    .irq_o    (irq_o),
    .sel_ok_o (sel_ok_o)
  );

endmodule

// File: rtl/clkfreq_guard_chk.sv
module clkfreq_guard_chk #(
  parameter int NUM_IN = 4
) (
  input logic              mclk,
  input logic              rst,
  input logic              chk_en_i,
  input logic [NUM_IN-1:0] clr_i,
  input logic [NUM_IN-1:0] irq_en_i,
  input logic [NUM_IN-1:0] valid_o,
  input logic [NUM_IN-1:0] chg_o,
  input logic              irq_o,
  input logic [NUM_IN-1:0] sel_ok_o
);

  // R3: disabled check forces every input valid
  a_r3_disable_all_valid: assert property (@(posedge mclk) disable iff (rst)
    !chk_en_i |=> (valid_o == '1));

  // R5: any valid flip leaves its change flag set
  a_r5_flip_sets_flag: assert property (@(posedge mclk) disable iff (rst)
    1'b1 |=> (((valid_o ^ $past(valid_o)) & ~chg_o) == '0));

  // R6: a flag only drops when cleared
  a_r6_sticky_hold: assert property (@(posedge mclk) disable iff (rst)
    1'b1 |=> ((($past(chg_o) & ~chg_o) & ~$past(clr_i)) == '0));

  // R6: clear without a coincident flip empties the flag
  a_r6_clear_works: assert property (@(posedge mclk) disable iff (rst)
    1'b1 |=> ((chg_o & $past(clr_i) & ~(valid_o ^ $past(valid_o))) == '0));

  // R7: enabled flag raises the request
  a_r7_irq_raise: assert property (@(posedge mclk) disable iff (rst)
    (|(chg_o & irq_en_i)) |=> irq_o);

  // R7: no enabled flag, no request
  a_r7_irq_quiet: assert property (@(posedge mclk) disable iff (rst)
    !(|(chg_o & irq_en_i)) |=> !irq_o);

  // R8: selectable only when valid
  a_r8_sel_needs_valid: assert property (@(posedge mclk) disable iff (rst)
    (sel_ok_o & ~valid_o) == '0);

  // R9: reset clears all status
  a_r9_reset_clear: assert property (@(posedge mclk)
    rst |=> (valid_o == '0 && chg_o == '0 && !irq_o && sel_ok_o == '0));

endmodule

bind clkfreq_guard clkfreq_guard_chk #(.NUM_IN(NUM_IN)) chk_i (
  .mclk     (mclk),
  .rst      (rst),
  .chk_en_i (chk_en_i),
  .clr_i    (clr_i),
  .irq_en_i (irq_en_i),
  .valid_o  (valid_o),
  .chg_o    (chg_o),
  .irq_o    (irq_o),
  .sel_ok_o (sel_ok_o)
);

// File: tb/clkfreq_guard_tb_top.sv
`timescale 1ns/1ps
module clkfreq_guard_tb_top;

  localparam int N      = 4;
  localparam int SETTLE = 1500;
  localparam int NVEC   = 4;

  // Input periods in master cycles (0 = stopped) and expected valid mask.
  localparam int VEC_PER [NVEC][N] = '{
    '{20, 20, 20, 20},
    '{20, 21, 19, 20},
    '{ 0, 20, 20, 22},
    '{20, 20, 20, 20}
  };
  localparam logic [N-1:0] VEC_EXP [NVEC] = '{4'b1111, 4'b1001, 4'b0110, 4'b1111};

  logic         mclk = 1'b0;
  logic         rst  = 1'b1;
  logic [N-1:0] ref_clk = '0;
  logic         chk_en = 1'b1;
  logic [N-1:0] clr = '0;
  logic [N-1:0] irq_en = '0;
  logic [N-1:0] valid, chg, sel_ok;
  logic         irq;

  int per [N];
  int ph  [N];
  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2.5 mclk = ~mclk;

  clkfreq_guard #(.NUM_IN(N)) dut_i (
    .mclk      (mclk),
    .rst       (rst),
    .ref_clk_i (ref_clk),
    .chk_en_i  (chk_en),
    .clr_i     (clr),
    .irq_en_i  (irq_en),
    .valid_o   (valid),
    .chg_o     (chg),
    .irq_o     (irq),
    .sel_ok_o  (sel_ok)
  );

  // Test clocks built from whole master cycles on falling edges.
  always @(negedge mclk) begin
    for (int i = 0; i < N; i++) begin
      if (per[i] == 0) begin
        ref_clk[i] <= 1'b0;
        ph[i]      <= 0;
      end else begin
        ref_clk[i] <= (ph[i] < per[i] / 2);
        ph[i]      <= (ph[i] + 1 >= per[i]) ? 0 : ph[i] + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge mclk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin per[i] = 20; ph[i] = 0; end
    cycles(4);
    // R9: reset state
    check("R9 valid", valid, 0);
    check("R9 chg", chg, 0);
    check("R9 irq", irq, 0);
    rst = 1'b0;
    cycles(SETTLE);
    // R1/R4: nominal inputs become valid; R5 rising flips flagged
    check("R1 valid nominal", valid, 4'b1111);
    check("R5 rise flags", chg, 4'b1111);
    check("R7 irq masked", irq, 0);
    irq_en = 4'b0001;
    cycles(1);
    cycles(1);
    check("R7 irq raised", irq, 1);
    clr = 4'b0001;
    cycles(1);
    clr = '0;
    check("R6 clear bit0", chg, 4'b1110);
    cycles(1);
    check("R7 irq dropped", irq, 0);
    irq_en = '0;
    clr = 4'b1111;
    cycles(1);
    clr = '0;
    check("R6 clear all", chg, 0);

    // Vector walk: R1, R2, R4, R8
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < N; i++) per[i] = VEC_PER[v][i];
      cycles(SETTLE);
      check($sformatf("R2 R4 valid vec%0d", v), valid, VEC_EXP[v]);
      check($sformatf("R8 sel_ok vec%0d", v), sel_ok, VEC_EXP[v]);
    end

    // Stopped input 0, clear flags
    per[0] = 0;
    cycles(SETTLE);
    check("R2 stopped invalid", valid, 4'b1110);
    clr = 4'b1111;
    cycles(1);
    clr = '0;
    check("R6 clear before prio", chg, 0);
    // R3 + R6 priority: disable and clear on the same edge
    chk_en = 1'b0;
    clr    = 4'b0001;
    cycles(1);
    clr = '0;
    check("R3 disabled all valid", valid, 4'b1111);
    check("R6 flip beats clear", chg, 4'b0001);
    cycles(20);
    check("R3 still valid", valid, 4'b1111);
    clr = 4'b0001;
    cycles(1);
    clr = '0;
    check("R6 clear no flip", chg, 0);
    chk_en = 1'b1;
    cycles(600);
    check("R2 stopped after enable", valid, 4'b1110);
    check("R5 fall flag", chg, 4'b0001);
    check("R8 sel_ok stopped", sel_ok, 4'b1110);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule